// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks one on-chip phase-locked loop through a safe change of its divider settings. A single start pulse captures a new configuration (feedback multiplier, reference pre-divider, output post-divider, frequency-range select) together with two option bits and a wait limit. The block then takes the loop out of lock, changes the fields, and brings it back into lock. All register traffic goes through a narrow port. For each step the block drives one address and a write strobe. It reads the addressed word combinationally and alters only the bits of the field being changed.

The loop's lock indicator arrives as a single status input. The sequencer waits on it twice: for it to drop after the loop has been stopped or bypassed, and for it to rise after lock mode has been requested. Each wait is bounded by the captured cycle limit. If the limit runs out, the sequencer gives up and returns to idle with a timeout pulse. An optional erratum mode first writes the post-divider as one more than its target and then writes the true value.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o and reg_we_o are all low.
- R2: A start_i seen while idle is accepted, and busy_o is high from the next cycle. busy_o falls in the cycle where exactly one of done_o or timeout_o pulses high for one cycle; the two pulses never occur together.
- R3: The first write of a sequence puts the halt code into the mode field, bits [2:0] of the control register (address 0). The halt code is 3'd5 (bypass) when bypass_i was high at start and 3'd1 (stop) otherwise.
- R4: No divider, multiplier or range field is written until lock_status_i has been sampled low after the halt write. No write is issued while waiting.
- R5: After the unlock wait the writes follow this order: post-divider (address 2, bits [4:0]), multiplier (address 1, bits [18:8]), pre-divider (address 1, bits [6:0]), range select (address 0, bits [7:4]), then lock code 3'd7 into address 0, bits [2:0].
- R6: With erratum_fix_i high at start, the post-divider is written first as its value plus one, taken modulo 32, and then as its value, in two consecutive writes.
- R7: Every write changes only the bits of its own field; all other bits of the word keep the value read back.
- R8: In each wait the status is sampled on wait_limit_i+1 consecutive cycles, counting from the first cycle of the wait. If it never reaches the awaited level, timeout_o pulses, the block returns to idle and issues no further writes. A status match on the last sampled cycle is a success, not a timeout.
- R9: start_i while busy is ignored, and the configuration inputs are used only as captured at the accepted start.
- R10: done_o pulses only in the cycle after lock_status_i was sampled high in the lock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a reprogramming sequence |
| mult_i | input | 11 | Feedback multiplier value |
| prediv_i | input | 7 | Reference pre-divider value |
| postdiv_i | input | 5 | Output post-divider value |
| fsel_i | input | 4 | Frequency-range select value |
| erratum_fix_i | input | 1 | Write the post-divider as value+1, then value |
| bypass_i | input | 1 | Halt with bypass code instead of stop code |
| wait_limit_i | input | LIMIT_W | Last sampled cycle index of each status wait |
| lock_status_i | input | 1 | Lock indicator of the loop |
| reg_addr_o | output | ADDR_W | Register address for read-back and write |
| reg_rdata_i | input | 32 | Combinational read data of reg_addr_o |
| reg_we_o | output | 1 | Write strobe |
| reg_wdata_o | output | 32 | Merged write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle wait-expiry pulse |

## Verification
The case that needs care is a status change landing in the same cycle that the wait counter reaches its limit. Both the expiry and the advance want that cycle. The bench provokes it with a loop model whose status follows the mode field after a fixed, settable delay. With a limit of 3 and a delay of 3, the status changes exactly on the last sampled cycle, and the sequence must still end with done. With a delay of 4, timeout_o must appear five cycles after the start edge, with only the halt write logged.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int DATA_W = 32;
    localparam int MODE_W = 3;
    localparam int MULT_W = 11;
    localparam int PDIV_W = 7;
    localparam int POST_W = 5;
    localparam int FSEL_W = 4;

    localparam int MODE_LSB = 0;
    localparam int FSEL_LSB = 4;
    localparam int PDIV_LSB = 0;
    localparam int MULT_LSB = 8;
    localparam int POST_LSB = 0;

    localparam logic [MODE_W-1:0] MODE_STOP   = 3'd1;
    localparam logic [MODE_W-1:0] MODE_BYPASS = 3'd5;
    localparam logic [MODE_W-1:0] MODE_LOCK   = 3'd7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALT,
        ST_WAIT_OFF,
        ST_POST_BUMP,
        ST_POST,
        ST_MULT,
        ST_PDIV,
        ST_FSEL,
        ST_LOCK,
        ST_WAIT_ON
    } seq_state_e;

    typedef enum logic [1:0] {
        RG_CTRL,
        RG_MULT,
        RG_POST
    } reg_sel_e;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [PDIV_W-1:0] pdiv;
        logic [POST_W-1:0] post;
        logic [FSEL_W-1:0] fsel;
        logic              bump_en;
        logic              bypass;
    } pll_cfg_t;

    typedef struct packed {
        logic              req;
        reg_sel_e          sel;
        logic [DATA_W-1:0] value;
        logic [DATA_W-1:0] mask;
    } fld_wr_t;

    function automatic logic [DATA_W-1:0] field_mask(input int lsb, input int width);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i >= lsb) && (i < lsb + width);
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] field_place(input logic [DATA_W-1:0] v,
                                                      input int lsb, input int width);
        return (v << lsb) & field_mask(lsb, width);
    endfunction

endpackage

// File: rtl/pll_seq_wait_timer.sv
module pll_seq_wait_timer #(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               run_i,
    output logic               expired_o
);
    logic [LIMIT_W-1:0] limit_q;
    logic [LIMIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (load_i) begin
                limit_q <= limit_i;
            end
            if (!run_i) begin
                cnt_q <= '0;
            end else if (cnt_q != limit_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expired_o = run_i && (cnt_q == limit_q);

endmodule

// File: rtl/pll_seq_field_merge.sv
module pll_seq_field_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] field_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] merged_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign merged_o[b] = mask_i[b] ? field_i[b] : base_i[b];
    end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  pll_cfg_t cfg_i,
    input  logic     lock_status_i,
    input  logic     expired_i,
    output logic     load_o,
    output logic     wait_o,
    output fld_wr_t  wr_o,
    output logic     busy_o,
    output logic     done_o,
    output logic     timeout_o
);
    seq_state_e state_q, state_d;
    pll_cfg_t   cfg_q;
    logic       done_q, done_d;
    logic       to_q, to_d;
    logic [MODE_W-1:0] halt_code;
    logic [POST_W-1:0] post_bump;

    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        to_d    = 1'b0;
        load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_HALT;
                    load_o  = 1'b1;
                end
            end
            ST_HALT:      state_d = ST_WAIT_OFF;
            ST_WAIT_OFF: begin
                if (!lock_status_i) begin
                    state_d = cfg_q.bump_en ? ST_POST_BUMP : ST_POST;
                end else if (expired_i) begin
                    state_d = ST_IDLE;
                    to_d    = 1'b1;
                end
            end
            ST_POST_BUMP: state_d = ST_POST;
            ST_POST:      state_d = ST_MULT;
            ST_MULT:      state_d = ST_PDIV;
            ST_PDIV:      state_d = ST_FSEL;
            ST_FSEL:      state_d = ST_LOCK;
            ST_LOCK:      state_d = ST_WAIT_ON;
            ST_WAIT_ON: begin
                if (lock_status_i) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else if (expired_i) begin
                    state_d = ST_IDLE;
                    to_d    = 1'b1;
                end
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            to_q    <= to_d;
            if (load_o) begin
                cfg_q <= cfg_i;
            end
        end
    end

    assign halt_code = cfg_q.bypass ? MODE_BYPASS : MODE_STOP;
    assign post_bump = cfg_q.post + POST_W'(1);

    always_comb begin
        wr_o = '0;
        unique case (state_q)
            ST_HALT: begin
                wr_o.req   = 1'b1;
                wr_o.sel   = RG_CTRL;
                wr_o.value = field_place(DATA_W'(halt_code), MODE_LSB, MODE_W);
                wr_o.mask  = field_mask(MODE_LSB, MODE_W);
            end
            ST_POST_BUMP: begin
                wr_o.req   = 1'b1;
                wr_o.sel   = RG_POST;
                wr_o.value = field_place(DATA_W'(post_bump), POST_LSB, POST_W);
                wr_o.mask  = field_mask(POST_LSB, POST_W);
            end
            ST_POST: begin
                wr_o.req   = 1'b1;
                wr_o.sel   = RG_POST;
                wr_o.value = field_place(DATA_W'(cfg_q.post), POST_LSB, POST_W);
                wr_o.mask  = field_mask(POST_LSB, POST_W);
            end
            ST_MULT: begin
                wr_o.req   = 1'b1;
                wr_o.sel   = RG_MULT;
                wr_o.value = field_place(DATA_W'(cfg_q.mult), MULT_LSB, MULT_W);
                wr_o.mask  = field_mask(MULT_LSB, MULT_W);
            end
            ST_PDIV: begin
                wr_o.req   = 1'b1;
                wr_o.sel   = RG_MULT;
                wr_o.value = field_place(DATA_W'(cfg_q.pdiv), PDIV_LSB, PDIV_W);
                wr_o.mask  = field_mask(PDIV_LSB, PDIV_W);
            end
            ST_FSEL: begin
                wr_o.req   = 1'b1;
                wr_o.sel   = RG_CTRL;
                wr_o.value = field_place(DATA_W'(cfg_q.fsel), FSEL_LSB, FSEL_W);
                wr_o.mask  = field_mask(FSEL_LSB, FSEL_W);
            end
            ST_LOCK: begin
                wr_o.req   = 1'b1;
                wr_o.sel   = RG_CTRL;
                wr_o.value = field_place(DATA_W'(MODE_LOCK), MODE_LSB, MODE_W);
                wr_o.mask  = field_mask(MODE_LSB, MODE_W);
            end
            default: wr_o = '0;
        endcase
    end

    assign wait_o    = (state_q == ST_WAIT_OFF) || (state_q == ST_WAIT_ON);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign timeout_o = to_q;

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                LIMIT_W   = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd0,
    parameter logic [ADDR_W-1:0] MULT_ADDR = 4'd1,
    parameter logic [ADDR_W-1:0] POST_ADDR = 4'd2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [10:0]        mult_i,
    input  logic [6:0]         prediv_i,
    input  logic [4:0]         postdiv_i,
    input  logic [3:0]         fsel_i,
    input  logic               erratum_fix_i,
    input  logic               bypass_i,
    input  logic [LIMIT_W-1:0] wait_limit_i,
    input  logic               lock_status_i,
    output logic [ADDR_W-1:0]  reg_addr_o,
    input  logic [31:0]        reg_rdata_i,
    output logic               reg_we_o,
    output logic [31:0]        reg_wdata_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               timeout_o
);
    pll_cfg_t cfg;
    fld_wr_t  wr;
    logic     load;
    logic     waiting;
    logic     expired;

    always_comb begin
        cfg.mult    = mult_i;
        cfg.pdiv    = prediv_i;
        cfg.post    = postdiv_i;
        cfg.fsel    = fsel_i;
        cfg.bump_en = erratum_fix_i;
        cfg.bypass  = bypass_i;
    end

    pll_seq_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .cfg_i         (cfg),
        .lock_status_i (lock_status_i),
        .expired_i     (expired),
        .load_o        (load),
        .wait_o        (waiting),
        .wr_o          (wr),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .timeout_o     (timeout_o)
    );

    pll_seq_wait_timer #(.LIMIT_W(LIMIT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .limit_i   (wait_limit_i),
        .run_i     (waiting),
        .expired_o (expired)
    );

    always_comb begin
        unique case (wr.sel)
            RG_MULT: reg_addr_o = MULT_ADDR;
            RG_POST: reg_addr_o = POST_ADDR;
            default: reg_addr_o = CTRL_ADDR;
        endcase
    end

    pll_seq_field_merge #(.W(DATA_W)) u_merge (
        .base_i   (reg_rdata_i),
        .field_i  (wr.value),
        .mask_i   (wr.mask),
        .merged_o (reg_wdata_o)
    );

    assign reg_we_o = wr.req;

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic lock_status_i,
    input logic reg_we_o,
    input logic busy_o,
    input logic done_o,
    input logic timeout_o
);
    assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o || timeout_o));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(lock_status_i));

    assert_quiet_after_timeout_R8: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> !reg_we_o);

    assert_done_once_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .lock_status_i (lock_status_i),
    .reg_we_o      (reg_we_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .timeout_o     (timeout_o)
);

// File: tb/pll_reprog_seq_tb_top.sv
module pll_reprog_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int LIMIT_W    = 16;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_MULT = 4'd1;
    localparam logic [ADDR_W-1:0] A_POST = 4'd2;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic [10:0]        mult;
    logic [6:0]         prediv;
    logic [4:0]         postdiv;
    logic [3:0]         fsel;
    logic               fix;
    logic               byp;
    logic [LIMIT_W-1:0] limit;
    logic               lock_status;
    logic [ADDR_W-1:0]  reg_addr;
    logic [31:0]        reg_rdata;
    logic               reg_we;
    logic [31:0]        reg_wdata;
    logic               busy, done, timeout;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_reprog_seq #(
        .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W),
        .CTRL_ADDR(A_CTRL), .MULT_ADDR(A_MULT), .POST_ADDR(A_POST)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start),
        .mult_i(mult), .prediv_i(prediv), .postdiv_i(postdiv), .fsel_i(fsel),
        .erratum_fix_i(fix), .bypass_i(byp), .wait_limit_i(limit),
        .lock_status_i(lock_status),
        .reg_addr_o(reg_addr), .reg_rdata_i(reg_rdata), .reg_we_o(reg_we),
        .reg_wdata_o(reg_wdata),
        .busy_o(busy), .done_o(done), .timeout_o(timeout)
    );

    // register file and write log
    logic [31:0] regs [16];
    logic [3:0]  log_a [256];
    logic [31:0] log_d [256];
    logic        log_s [256];
    int          log_n;

    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) regs[i] <= 32'h0;
            regs[A_CTRL] <= 32'hC3A5_5A07;
            regs[A_MULT] <= 32'h5A5A_A5A5;
            regs[A_POST] <= 32'hF0F0_0F0F;
            log_n <= 0;
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            if (log_n < 256) begin
                log_a[log_n] <= reg_addr;
                log_d[log_n] <= reg_wdata;
                log_s[log_n] <= lock_status;
                log_n <= log_n + 1;
            end
        end
    end

    // loop model: status follows the mode field after pll_delay cycles
    int pll_delay = 2;
    bit pll_stuck = 1'b0;
    bit pll_no_lock = 1'b0;
    int pcnt;
    logic pll_target;
    assign pll_target = (regs[A_CTRL][2:0] == 3'd7);

    always @(posedge clk) begin
        if (rst) begin
            lock_status <= 1'b1;
            pcnt <= 0;
        end else if (pll_stuck || (pll_target && pll_no_lock) || (pll_target == lock_status)) begin
            pcnt <= 0;
        end else if (pcnt + 1 >= pll_delay) begin
            lock_status <= pll_target;
            pcnt <= 0;
        end else begin
            pcnt <= pcnt + 1;
        end
    end

    // expected write list
    logic [3:0]  exp_a [8];
    logic [31:0] exp_d [8];
    int          exp_n;

    function automatic logic [31:0] mrg(input logic [31:0] old, input int lsb,
                                        input int w, input logic [31:0] val);
        logic [31:0] m;
        m = ((32'h1 << w) - 32'h1) << lsb;
        return (old & ~m) | ((val << lsb) & m);
    endfunction

    task automatic push(input logic [3:0] a, input logic [31:0] d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_expect(input logic [10:0] m, input logic [6:0] n,
                                input logic [4:0] p2, input logic [3:0] fs,
                                input bit wa, input bit bp);
        logic [31:0] c, mu, p;
        c = regs[A_CTRL]; mu = regs[A_MULT]; p = regs[A_POST];
        exp_n = 0;
        c = mrg(c, 0, 3, bp ? 32'd5 : 32'd1);  push(A_CTRL, c);
        if (wa) begin
            p = mrg(p, 0, 5, {27'd0, p2 + 5'd1}); push(A_POST, p);
        end
        p  = mrg(p, 0, 5, {27'd0, p2});   push(A_POST, p);
        mu = mrg(mu, 8, 11, {21'd0, m});  push(A_MULT, mu);
        mu = mrg(mu, 0, 7, {25'd0, n});   push(A_MULT, mu);
        c  = mrg(c, 4, 4, {28'd0, fs});   push(A_CTRL, c);
        c  = mrg(c, 0, 3, 32'd7);         push(A_CTRL, c);
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // compare logged writes from base against the first cnt expected entries
    task automatic verify_log(input int base, input int cnt);
        check_eq("R5", "write count", log_n - base, cnt);
        for (int i = 0; i < cnt && base + i < log_n; i++) begin
            check_eq("R5", $sformatf("addr of write %0d", i), {28'd0, log_a[base+i]}, {28'd0, exp_a[i]});
            check_eq("R7", $sformatf("data of write %0d", i), log_d[base+i], exp_d[i]);
        end
    endtask

    task automatic launch(input logic [10:0] m, input logic [6:0] n,
                          input logic [4:0] p2, input logic [3:0] fs,
                          input bit wa, input bit bp, input int lim);
        @(negedge clk);
        mult = m; prediv = n; postdiv = p2; fsel = fs;
        fix = wa; byp = bp; limit = LIMIT_W'(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R2", "busy after start", {31'd0, busy}, 32'd1);
    endtask

    task automatic wait_end(output int k);
        k = 0;
        while (!(done || timeout) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 3000) check_eq("R2", "sequence end seen", 32'd0, 32'd1);
        check_eq("R2", "busy low at end", {31'd0, busy}, 32'd0);
        check_eq("R2", "done and timeout exclusive", {31'd0, done && timeout}, 32'd0);
    endtask

    task automatic run_full(input logic [10:0] m, input logic [6:0] n,
                            input logic [4:0] p2, input logic [3:0] fs,
                            input bit wa, input bit bp, input int lim, input int dly);
        int base, k;
        pll_delay = dly;
        @(negedge clk);
        build_expect(m, n, p2, fs, wa, bp);
        base = log_n;
        launch(m, n, p2, fs, wa, bp, lim);
        wait_end(k);
        check_eq("R10", "done pulse", {31'd0, done}, 32'd1);
        check_eq("R10", "status high at done", {31'd0, lock_status}, 32'd1);
        check_eq("R8", "no timeout", {31'd0, timeout}, 32'd0);
        verify_log(base, exp_n);
        check_eq("R3", "halt write data", log_d[base], exp_d[0]);
        for (int i = 1; i < exp_n && base + i < log_n; i++) begin
            check_eq("R4", $sformatf("status low at write %0d", i), {31'd0, log_s[base+i]}, 32'd0);
        end
        @(negedge clk);
        check_eq("R2", "done single cycle", {31'd0, done}, 32'd0);
        check_eq("R7", "final control word", regs[A_CTRL], exp_d[exp_n-1]);
    endtask

    task automatic test_reset();
        check_eq("R1", "busy", {31'd0, busy}, 32'd0);
        check_eq("R1", "done", {31'd0, done}, 32'd0);
        check_eq("R1", "timeout", {31'd0, timeout}, 32'd0);
        check_eq("R1", "write strobe", {31'd0, reg_we}, 32'd0);
    endtask

    task automatic test_basic();
        run_full(11'h2A5, 7'h0C, 5'h01, 4'h7, 1'b0, 1'b0, 20, 2);
        run_full(11'h7FF, 7'h7F, 5'h1E, 4'hF, 1'b0, 1'b0, 20, 1);
    endtask

    task automatic test_bypass_bump();
        // R6 with wrap: post-divider 31 gives a first write of 0
        run_full(11'h013, 7'h01, 5'h1F, 4'h2, 1'b1, 1'b1, 20, 1);
        check_eq("R6", "wrapped bump value", exp_d[1] & 32'h1F, 32'h0);
        run_full(11'h100, 7'h05, 5'h09, 4'h3, 1'b1, 1'b0, 30, 5);
    endtask

    task automatic test_limit_edge();
        int base, k;
        // status arrives on the last sampled cycle: success
        run_full(11'h0AA, 7'h11, 5'h04, 4'h1, 1'b0, 1'b0, 3, 3);
        // one cycle later: timeout in the unlock wait
        pll_delay = 4;
        @(negedge clk);
        build_expect(11'h055, 7'h22, 5'h08, 4'h6, 1'b0, 1'b0);
        base = log_n;
        launch(11'h055, 7'h22, 5'h08, 4'h6, 1'b0, 1'b0, 3);
        wait_end(k);
        check_eq("R8", "timeout pulse at limit edge", {31'd0, timeout}, 32'd1);
        check_eq("R8", "timeout cycle", k, 5);
        repeat (6) @(negedge clk);
        verify_log(base, 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic test_stuck();
        int base, k;
        run_full(11'h123, 7'h03, 5'h02, 4'h4, 1'b0, 1'b0, 20, 2);
        pll_stuck = 1'b1;
        @(negedge clk);
        build_expect(11'h321, 7'h30, 5'h10, 4'h8, 1'b0, 1'b1);
        base = log_n;
        launch(11'h321, 7'h30, 5'h10, 4'h8, 1'b0, 1'b1, 5);
        wait_end(k);
        check_eq("R8", "timeout on unlock wait", {31'd0, timeout}, 32'd1);
        check_eq("R8", "no done on timeout", {31'd0, done}, 32'd0);
        check_eq("R8", "unlock timeout cycle", k, 7);
        repeat (8) @(negedge clk);
        check_eq("R4", "no divider write without unlock", log_n - base, 1);
        check_eq("R3", "bypass halt data", log_d[base], exp_d[0]);
        pll_stuck = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic test_no_lock();
        int base, k;
        pll_no_lock = 1'b1;
        pll_delay = 2;
        @(negedge clk);
        build_expect(11'h0F0, 7'h0F, 5'h03, 4'h9, 1'b0, 1'b0);
        base = log_n;
        launch(11'h0F0, 7'h0F, 5'h03, 4'h9, 1'b0, 1'b0, 6);
        wait_end(k);
        check_eq("R8", "timeout on lock wait", {31'd0, timeout}, 32'd1);
        check_eq("R10", "no done without lock", {31'd0, done}, 32'd0);
        repeat (5) @(negedge clk);
        verify_log(base, 6);
        pll_no_lock = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic test_restart_ignored();
        int base, k;
        pll_delay = 3;
        @(negedge clk);
        build_expect(11'h2C3, 7'h44, 5'h0A, 4'hB, 1'b1, 1'b0);
        base = log_n;
        launch(11'h2C3, 7'h44, 5'h0A, 4'hB, 1'b1, 1'b0, 20);
        @(negedge clk);
        mult = 11'h001; prediv = 7'h01; postdiv = 5'h01; fsel = 4'h0;
        fix = 1'b0; byp = 1'b1; limit = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R9", "busy after ignored start", {31'd0, busy}, 32'd1);
        wait_end(k);
        check_eq("R9", "done with first config", {31'd0, done}, 32'd1);
        repeat (6) @(negedge clk);
        check_eq("R9", "no restart after done", {31'd0, busy}, 32'd0);
        verify_log(base, exp_n);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        mult = '0; prediv = '0; postdiv = '0; fsel = '0;
        fix = 1'b0; byp = 1'b0; limit = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_basic();
        test_bypass_bump();
        test_limit_edge();
        test_stuck();
        test_no_lock();
        test_restart_ignored();
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule